// File: doc/BRIEF.md
# Byte-Wide Access Bridge for 16-bit Control Fields

This block holds a small set of 16-bit control and status fields and exposes them to a CPU through an 8-bit request/acknowledge port with a 4-bit byte address. Every field spans two neighbouring byte addresses. Software reaches each field with two byte accesses, and the block makes the pair behave as one wide access. On a read, the low-byte access captures the upper byte into a snapshot register. On a write, the low byte waits in a staging register until the high byte arrives.

Towards the hardware side, each field drives its present value together with single-cycle strobes. One strobe marks a software access and the other marks a software change. One field is not stored in the block: it is sampled from a live 16-bit hardware input at the moment software touches it. Another field empties itself when software reads it.

Byte pair map (low byte at the even address): 0x0/0x1 sampled input field (read-only); 0x2/0x3 control field with a change strobe; 0x4/0x5 clear-on-read event field; 0x6/0x7 and 0x8/0x9 two threshold fields, each with both strobes; 0xA to 0xF unmapped.

Top module: `wide_reg_bridge`

## Requirements
- R1: After a synchronous active-high reset, the control, event, first threshold and second threshold fields show 0x4020, 0x1030, 0x1234 and 0xABCD. At the same time `ack` is low, no strobe is high, and the staging and snapshot registers hold zero.
- R2: Every cycle with `req` high is answered by `ack` high in the next cycle. `rdata` is valid in that `ack` cycle. Reads from addresses 0xA to 0xF return 0x00, and writes to those addresses change nothing.
- R3: A field's low byte sits at the even address and its high byte at the following odd address, following the byte pair map.
- R4: A read of address 0x0 pulses `sense_acc` in its request cycle and samples `hw_in` in that same cycle. It returns bits 7:0 of the sample, and a later read of 0x1 returns bits 15:8 of the sample, not the live input.
- R5: A full two-byte read of the sampled field produces exactly one `sense_acc` pulse. A read of 0x1 does not pulse it.
- R6: A write to a writable low byte (0x2, 0x6, 0x8) only loads the staging register, and no field output changes. A write to the matching odd address loads the field with {write data, staged byte}.
- R7: The change strobe of a writable field is high only in the request cycle of the committing high-byte write. The field output takes the new value in the following cycle, e.g. 0x4020 becomes 0x4221 after writing 0x21 to 0x2 and then 0x42 to 0x3.
- R8: For both threshold fields, the access and change strobes rise together in the committing cycle and are both low in every other cycle, including the low-byte write cycle.
- R9: Reading 0x4 and then 0x5 returns the event field's low and then high byte, e.g. 0x30 then 0x10 for 0x1030. `evt_mod` pulses once, in the 0x4 request cycle, and the field is zero from the next cycle onward.
- R10: The staging register is shared by all writable fields. A high-byte write with no low-byte write before it commits using whatever byte the staging register last held, which is 0x00 after reset.
- R11: Writes to 0x0, 0x1, 0x4 and 0x5 are ignored: no field changes and no strobe pulses.
- R12: A read of any odd mapped address returns the upper byte captured by the most recent low-byte read. Writes made between the two reads do not change what is returned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Byte access request, one cycle per access |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 4 | Byte address |
| wdata | input | 8 | Write byte |
| rdata | output | 8 | Read byte, valid with ack |
| ack | output | 1 | Acknowledge, one cycle after req |
| hw_in | input | 16 | Live hardware value for the sampled field |
| sense_acc | output | 1 | Sampled field access strobe |
| ctrl_val | output | 16 | Control field value |
| ctrl_mod | output | 1 | Control field change strobe |
| evt_val | output | 16 | Clear-on-read event field value |
| evt_mod | output | 1 | Event field change (clear) strobe |
| thr_val | output | 16 | First threshold field value |
| thr_acc | output | 1 | First threshold access strobe |
| thr_mod | output | 1 | First threshold change strobe |
| lim_val | output | 16 | Second threshold field value |
| lim_acc | output | 1 | Second threshold access strobe |
| lim_mod | output | 1 | Second threshold change strobe |

## Verification
The sampled field is the case where two functions share one clock cycle: the access strobe and the capture of the hardware input. The bench provokes this by changing `hw_in` on every clock while it reads 0x0 and then 0x1. It then judges that both bytes returned equal the value present in the single cycle where `sense_acc` was high, and that the pulse counter reads exactly one. The threshold fields give a second same-cycle pairing: the bench requires both of their strobes inside the committing request cycle, and the new value one cycle later.

// File: rtl/wide_reg_bridge.sv
module wide_reg_bridge #(
  parameter logic [15:0] CTRL_INIT = 16'h4020,
  parameter logic [15:0] EVT_INIT  = 16'h1030,
  parameter logic [15:0] THR_INIT  = 16'h1234,
  parameter logic [15:0] LIM_INIT  = 16'hABCD
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        req,
  input  logic        we,
  input  logic [3:0]  addr,
  input  logic [7:0]  wdata,
  output logic [7:0]  rdata,
  output logic        ack,
  input  logic [15:0] hw_in,
  output logic        sense_acc,
  output logic [15:0] ctrl_val,
  output logic        ctrl_mod,
  output logic [15:0] evt_val,
  output logic        evt_mod,
  output logic [15:0] thr_val,
  output logic        thr_acc,
  output logic        thr_mod,
  output logic [15:0] lim_val,
  output logic        lim_acc,
  output logic        lim_mod
);

  logic       rd, wr, hi, mapped, stage_ld;
  logic [2:0] fld;
  logic [7:0] stage_lo, snap_hi;
  logic [15:0] cur;

  assign rd  = req & ~we & ~rst;
  assign wr  = req &  we & ~rst;
  assign fld = addr[3:1];
  assign hi  = addr[0];
  assign mapped = (fld <= 3'd4);
  assign stage_ld = wr & ~hi & (fld == 3'd1 || fld == 3'd3 || fld == 3'd4);

  assign sense_acc = rd & (addr == 4'h0);
  assign ctrl_mod  = wr & (addr == 4'h3);
  assign evt_mod   = rd & (addr == 4'h4);
  assign thr_mod   = wr & (addr == 4'h7);
  assign thr_acc   = thr_mod;
  assign lim_mod   = wr & (addr == 4'h9);
  assign lim_acc   = lim_mod;

  always_comb begin
    case (fld)
      3'd0:    cur = hw_in;
      3'd1:    cur = ctrl_val;
      3'd2:    cur = evt_val;
      3'd3:    cur = thr_val;
      3'd4:    cur = lim_val;
      default: cur = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ack      <= 1'b0;
      rdata    <= '0;
      stage_lo <= '0;
      snap_hi  <= '0;
      ctrl_val <= CTRL_INIT;
      evt_val  <= EVT_INIT;
      thr_val  <= THR_INIT;
      lim_val  <= LIM_INIT;
    end else begin
      ack <= req;
      if (req)
        rdata <= (rd && mapped) ? (hi ? snap_hi : cur[7:0]) : 8'h00;
      if (rd && mapped && !hi)
        snap_hi <= cur[15:8];
      if (stage_ld)
        stage_lo <= wdata;
      if (ctrl_mod) ctrl_val <= {wdata, stage_lo};
      if (thr_mod)  thr_val  <= {wdata, stage_lo};
      if (lim_mod)  lim_val  <= {wdata, stage_lo};
      if (evt_mod)  evt_val  <= '0;
    end
  end

endmodule

// File: rtl/wide_reg_bridge_chk.sv
module wide_reg_bridge_chk (
  input logic        clk,
  input logic        rst,
  input logic        req,
  input logic        we,
  input logic [3:0]  addr,
  input logic [7:0]  rdata,
  input logic        ack,
  input logic        sense_acc,
  input logic [15:0] ctrl_val,
  input logic        ctrl_mod,
  input logic [15:0] evt_val,
  input logic        evt_mod,
  input logic [15:0] thr_val,
  input logic        thr_acc,
  input logic        thr_mod,
  input logic [15:0] lim_val,
  input logic        lim_acc,
  input logic        lim_mod
);

  AST_ACK_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (rst) req |=> ack); // R2
  AST_NO_SPURIOUS_ACK: assert property (@(posedge clk) disable iff (rst) !req |=> !ack); // R2
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
    (req && !we && addr >= 4'hA) |=> (ack && rdata == 8'h00)); // R2
  AST_SENSE_ON_LOW_READ: assert property (@(posedge clk) disable iff (rst)
    sense_acc |-> (req && !we && addr == 4'h0)); // R5
  AST_CTRL_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !ctrl_mod |=> $stable(ctrl_val)); // R7
  AST_THR_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !(thr_acc && thr_mod) |=> $stable(thr_val)); // R8
  AST_LIM_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !(lim_acc && lim_mod) |=> $stable(lim_val)); // R8
  AST_EVT_CLEARS: assert property (@(posedge clk) disable iff (rst)
    evt_mod |=> (evt_val == 16'h0000)); // R9
  AST_EVT_ONLY_BY_READ: assert property (@(posedge clk) disable iff (rst)
    !evt_mod |=> $stable(evt_val)); // R11

endmodule

bind wide_reg_bridge wide_reg_bridge_chk u_chk (
  .clk(clk), .rst(rst), .req(req), .we(we), .addr(addr), .rdata(rdata), .ack(ack),
  .sense_acc(sense_acc), .ctrl_val(ctrl_val), .ctrl_mod(ctrl_mod),
  .evt_val(evt_val), .evt_mod(evt_mod), .thr_val(thr_val), .thr_acc(thr_acc),
  .thr_mod(thr_mod), .lim_val(lim_val), .lim_acc(lim_acc), .lim_mod(lim_mod)
);

// File: tb/wide_reg_bridge_tb.sv
module wide_reg_bridge_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req = 1'b0;
  logic        we = 1'b0;
  logic [3:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic [15:0] hw_in = 16'h0000;
  logic [7:0]  rdata;
  logic        ack, sense_acc, ctrl_mod, evt_mod, thr_acc, thr_mod, lim_acc, lim_mod;
  logic [15:0] ctrl_val, evt_val, thr_val, lim_val;

  int checks = 0;
  int fails = 0;
  int sense_cnt = 0;
  int evt_cnt = 0;
  bit hw_run = 0;
  bit done = 0;

  logic [7:0]  got;
  logic        got_ack;
  logic [15:0] cap_hw;
  logic        s_sense, s_ctrl, s_evt, s_thr_a, s_thr_m, s_lim_a, s_lim_m;
  logic [15:0] s_thr_val;

  always #2 clk = ~clk;

  wide_reg_bridge u_dut (
    .clk(clk), .rst(rst), .req(req), .we(we), .addr(addr), .wdata(wdata),
    .rdata(rdata), .ack(ack), .hw_in(hw_in), .sense_acc(sense_acc),
    .ctrl_val(ctrl_val), .ctrl_mod(ctrl_mod), .evt_val(evt_val), .evt_mod(evt_mod),
    .thr_val(thr_val), .thr_acc(thr_acc), .thr_mod(thr_mod),
    .lim_val(lim_val), .lim_acc(lim_acc), .lim_mod(lim_mod)
  );

  always @(posedge clk) begin
    if (!rst && sense_acc) sense_cnt <= sense_cnt + 1;
    if (!rst && evt_mod)   evt_cnt   <= evt_cnt + 1;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic access(input logic w, input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    if (hw_run) hw_in = hw_in + 16'h0101;
    req = 1'b1; we = w; addr = a; wdata = d;
    #1;
    cap_hw = hw_in;
    s_sense = sense_acc; s_ctrl = ctrl_mod; s_evt = evt_mod;
    s_thr_a = thr_acc; s_thr_m = thr_mod; s_lim_a = lim_acc; s_lim_m = lim_mod;
    s_thr_val = thr_val;
    @(negedge clk);
    if (hw_run) hw_in = hw_in + 16'h0101;
    req = 1'b0; we = 1'b0;
    #1;
    got = rdata; got_ack = ack;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  // {check, we, addr, wdata, expected rdata}
  localparam int NV = 18;
  localparam logic [21:0] VEC [NV] = '{
    {1'b1, 1'b0, 4'h2, 8'h00, 8'h20},  // R3 ctrl low
    {1'b1, 1'b0, 4'h3, 8'h00, 8'h40},  // R3 ctrl high
    {1'b1, 1'b0, 4'h6, 8'h00, 8'h34},  // R3 thr low
    {1'b1, 1'b0, 4'h7, 8'h00, 8'h12},
    {1'b1, 1'b0, 4'h8, 8'h00, 8'hCD},  // R3 lim low
    {1'b1, 1'b0, 4'h9, 8'h00, 8'hAB},
    {1'b0, 1'b1, 4'hA, 8'h55, 8'h00},  // R2 unmapped write
    {1'b1, 1'b0, 4'hA, 8'h00, 8'h00},  // R2 unmapped read
    {1'b1, 1'b0, 4'hF, 8'h00, 8'h00},
    {1'b0, 1'b1, 4'h4, 8'hFF, 8'h00},  // R11 write to event field
    {1'b0, 1'b1, 4'h5, 8'hEE, 8'h00},
    {1'b0, 1'b1, 4'h0, 8'h77, 8'h00},  // R11 write to sampled field
    {1'b0, 1'b1, 4'h1, 8'h66, 8'h00},
    {1'b0, 1'b1, 4'h2, 8'h21, 8'h00},  // R7 ctrl write
    {1'b0, 1'b1, 4'h3, 8'h42, 8'h00},
    {1'b1, 1'b0, 4'h2, 8'h00, 8'h21},
    {1'b1, 1'b0, 4'h3, 8'h00, 8'h42},
    {1'b1, 1'b0, 4'hB, 8'h00, 8'h00}
  };

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    chk("R1 ctrl reset", ctrl_val, 16'h4020);
    chk("R1 evt reset", evt_val, 16'h1030);
    chk("R1 thr reset", thr_val, 16'h1234);
    chk("R1 lim reset", lim_val, 16'hABCD);
    chk("R1 ack low", ack, 0);
    chk("R1 strobes low", {sense_acc, ctrl_mod, evt_mod, thr_acc, thr_mod, lim_acc, lim_mod}, 0);

    for (int i = 0; i < NV; i++) begin
      access(VEC[i][20], VEC[i][19:16], VEC[i][15:8]);
      chk("R2 ack", got_ack, 1);
      if (VEC[i][21]) chk("R3 table read", got, VEC[i][7:0]);
    end
    chk("R7 ctrl committed", ctrl_val, 16'h4221);
    chk("R11 evt untouched", evt_val, 16'h1030);
    chk("R11 no evt pulse", evt_cnt, 0);

    // threshold write
    access(1'b1, 4'h6, 8'h67);
    chk("R6 low write no change", thr_val, 16'h1234);
    chk("R8 no strobes on low write", {s_thr_a, s_thr_m}, 2'b00);
    access(1'b1, 4'h7, 8'h45);
    chk("R8 both strobes on commit", {s_thr_a, s_thr_m}, 2'b11);
    chk("R7 value old during strobe", s_thr_val, 16'h1234);
    chk("R6 thr committed", thr_val, 16'h4567);
    chk("R8 strobes drop", {thr_acc, thr_mod}, 2'b00);
    access(1'b1, 4'h8, 8'h12);
    access(1'b1, 4'h9, 8'hEF);
    chk("R8 lim strobes", {s_lim_a, s_lim_m}, 2'b11);
    chk("R6 lim committed", lim_val, 16'hEF12);

    // clear on read
    access(1'b0, 4'h4, 8'h00);
    chk("R9 low byte", got, 8'h30);
    chk("R9 strobe in low read", s_evt, 1);
    chk("R9 cleared", evt_val, 16'h0000);
    access(1'b0, 4'h5, 8'h00);
    chk("R9 high byte", got, 8'h10);
    chk("R9 no strobe on high read", s_evt, 0);
    chk("R9 one pulse", evt_cnt, 1);
    access(1'b0, 4'h4, 8'h00);
    chk("R9 reads zero after", got, 8'h00);

    // sampled field with a moving input
    hw_in = 16'h5A3C;
    hw_run = 1;
    sense_cnt = 0;
    access(1'b0, 4'h0, 8'h00);
    chk("R4 strobe on low read", s_sense, 1);
    chk("R4 low byte sampled", got, cap_hw[7:0]);
    access(1'b0, 4'h1, 8'h00);
    chk("R4 high byte from capture", got, cap_hw[15:8] - 8'h02);
    chk("R5 no strobe on high read", s_sense, 0);
    chk("R5 single pulse", sense_cnt, 1);
    hw_run = 0;

    // shared staging register
    do_reset();
    access(1'b1, 4'h3, 8'h77);
    chk("R10 stage zero after reset", ctrl_val, 16'h7700);
    access(1'b1, 4'h2, 8'h11);
    access(1'b1, 4'h3, 8'h22);
    chk("R10 ctrl", ctrl_val, 16'h2211);
    access(1'b1, 4'h9, 8'h33);
    chk("R10 reuse stage", lim_val, 16'h3311);

    // snapshot atomicity
    access(1'b0, 4'h2, 8'h00);
    chk("R12 low read", got, 8'h11);
    access(1'b1, 4'h2, 8'h99);
    access(1'b1, 4'h3, 8'h88);
    access(1'b0, 4'h3, 8'h00);
    chk("R12 snapshot high", got, 8'h22);
    chk("R12 field updated", ctrl_val, 16'h8899);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule